// File: doc/BRIEF.md
# Cartridge Pin Port for a Serial Real-Time Clock

This block puts a small three-pin I/O port into the address space of a cartridge ROM, so that software running on the console can talk to a serial real-time clock by toggling pins. Three halfword registers sit at fixed byte offsets: a pin-value register at 0xC4, a pin-direction register at 0xC6 and a mode register at 0xC8. Software writes these registers to drive or release the clock's serial clock, serial data and chip-select lines, and it runs the clock's command protocol itself.

The address comes from the shared bus address latch of the cartridge. Writes to the port offsets also reach the flash, which ignores them because they do not form a valid command sequence. Reads return port contents only once the mode register allows reading. Otherwise the flash data passes through unchanged. The clock's interrupt output is inverted onto the active-low cartridge interrupt line.

Top module: `cart_gpio_port`

## Requirements
- R1: After reset the pin-value, pin-direction and mode registers are all zero: `pin_out` is 0, `pin_oe` is 0 (every pin is released), and the port is in write-only mode.
- R2: A write strobe at byte address 0xC4 stores `wr_data[2:0]` on the following clock edge; bit 0 drives the serial clock pin, bit 1 the serial data pin and bit 2 the chip-select pin. Bits 15:3 of the written value are ignored.
- R3: A write strobe at byte address 0xC6 stores `wr_data[2:0]` as the pin directions; a bit of 1 makes that pin an output (`pin_oe` bit high), and a bit of 0 releases it so the clock chip can drive it.
- R4: While mode bit 0 (written at 0xC8) is 0, reads of 0xC4, 0xC6 and 0xC8 return `flash_rdata`.
- R5: While mode bit 0 is 1, a read of 0xC4 returns the live pin levels in bits 2:0 and zero in bits 15:3. An output pin reads its stored value, and an input pin reads `pin_in`.
- R6: While mode bit 0 is 1, a read of 0xC6 returns the direction bits in bits 2:0, and a read of 0xC8 returns the mode bit in bit 0. All other bits read as zero.
- R7: The register decode compares the full latched address. Any address that differs from 0xC4, 0xC6 or 0xC8 in any bit, including higher address bits and the lowest bit, changes no register and reads back as flash data.
- R8: `cart_irq_n` is the logical inverse of `rtc_irq`, with no clock delay.
- R9: Reads of addresses outside the three port offsets always return `flash_rdata`, whatever the mode bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Latched byte address of the current access |
| wr_strobe | input | 1 | One-cycle write pulse for the current address |
| wr_data | input | 16 | Write data from the bus |
| rd_en | input | 1 | Read access in progress |
| flash_rdata | input | 16 | Data returned by the flash for the current address |
| rd_data | output | 16 | Read data returned to the bus |
| pin_in | input | 3 | Sensed levels of clock, data and select pins |
| pin_out | output | 3 | Values driven on the pins when enabled |
| pin_oe | output | 3 | Per-pin output enable |
| rtc_irq | input | 1 | Interrupt output of the clock chip |
| cart_irq_n | output | 1 | Active-low cartridge interrupt line |

## Verification
The assertions assume that the address latch holds `bus_addr` steady over a whole write. They also assume that `wr_strobe` is a clean one-cycle pulse that is only ever sampled at clock edges. The bench therefore changes every input on the falling edge, holds the address and data for the full cycle of a strobe, and lowers the strobe before the next rising edge. The checks on the read path assume that `flash_rdata` and `pin_in` settle before the output is sampled. The bench changes those inputs and then waits a fixed delay before it compares.

// File: rtl/cart_gpio_port.sv
module cart_gpio_port #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int PINS = 3,
  parameter logic [ADDR_W-1:0] VAL_OFS = 'hC4,
  parameter logic [ADDR_W-1:0] DIR_OFS = 'hC6,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'hC8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              wr_strobe,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] flash_rdata,
  output logic [DATA_W-1:0] rd_data,
  input  logic [PINS-1:0]   pin_in,
  output logic [PINS-1:0]   pin_out,
  output logic [PINS-1:0]   pin_oe,
  input  logic              rtc_irq,
  output logic              cart_irq_n
);

  localparam int PAD_W = DATA_W - PINS;

  logic [PINS-1:0] val_q, dir_q, pin_level;
  logic            mode_q;
  logic            hit_val, hit_dir, hit_mode;
  logic            unused_hi;

  assign hit_val  = (bus_addr == VAL_OFS);
  assign hit_dir  = (bus_addr == DIR_OFS);
  assign hit_mode = (bus_addr == MODE_OFS);
  assign unused_hi = ^wr_data[DATA_W-1:PINS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      dir_q  <= '0;
      mode_q <= 1'b0;
    end else if (wr_strobe) begin
      if (hit_val)  val_q  <= wr_data[PINS-1:0];
      if (hit_dir)  dir_q  <= wr_data[PINS-1:0];
      if (hit_mode) mode_q <= wr_data[0];
    end
  end

  for (genvar i = 0; i < PINS; i++) begin : g_pin
    assign pin_level[i] = dir_q[i] ? val_q[i] : pin_in[i];
  end

  always_comb begin
    rd_data = flash_rdata;
    if (rd_en && mode_q) begin
      if (hit_val)       rd_data = {{PAD_W{1'b0}}, pin_level};
      else if (hit_dir)  rd_data = {{PAD_W{1'b0}}, dir_q};
      else if (hit_mode) rd_data = {{(DATA_W-1){1'b0}}, mode_q};
    end
  end

  assign pin_out    = val_q;
  assign pin_oe     = dir_q;
  assign cart_irq_n = ~rtc_irq;

endmodule

module cart_gpio_port_chk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16,
  parameter int PINS = 3,
  parameter logic [ADDR_W-1:0] VAL_OFS = 'hC4,
  parameter logic [ADDR_W-1:0] DIR_OFS = 'hC6,
  parameter logic [ADDR_W-1:0] MODE_OFS = 'hC8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              wr_strobe,
  input logic [DATA_W-1:0] wr_data,
  input logic              rd_en,
  input logic [DATA_W-1:0] flash_rdata,
  input logic [DATA_W-1:0] rd_data,
  input logic [PINS-1:0]   pin_out,
  input logic [PINS-1:0]   pin_oe,
  input logic              mode_q
);

  logic any_hit;
  assign any_hit = (bus_addr == VAL_OFS) || (bus_addr == DIR_OFS) || (bus_addr == MODE_OFS);

  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n |=> (pin_out == '0 && pin_oe == '0 && !mode_q));

  assert_value_write_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && bus_addr == VAL_OFS) |=> pin_out == $past(wr_data[PINS-1:0]));

  assert_dir_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && bus_addr == DIR_OFS) |=> pin_oe == $past(wr_data[PINS-1:0]));

  assert_write_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_q |-> rd_data == flash_rdata);

  assert_exact_decode_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_strobe && !any_hit) |=> ($stable(pin_out) && $stable(pin_oe) && $stable(mode_q)));

  assert_outside_flash_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !any_hit) |-> rd_data == flash_rdata);

endmodule

bind cart_gpio_port cart_gpio_port_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PINS(PINS),
  .VAL_OFS(VAL_OFS), .DIR_OFS(DIR_OFS), .MODE_OFS(MODE_OFS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_strobe(wr_strobe),
  .wr_data(wr_data), .rd_en(rd_en), .flash_rdata(flash_rdata),
  .rd_data(rd_data), .pin_out(pin_out), .pin_oe(pin_oe), .mode_q(mode_q)
);

// File: tb/test_cart_gpio_port.sv
module test_cart_gpio_port;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] bus_addr = '0;
  logic        wr_strobe = 1'b0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [15:0] flash_rdata = 16'h1234;
  logic [15:0] rd_data;
  logic [2:0]  pin_in = '0;
  logic [2:0]  pin_out, pin_oe;
  logic        rtc_irq = 1'b0;
  logic        cart_irq_n;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  cart_gpio_port i_cart_gpio_port (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .wr_strobe(wr_strobe),
    .wr_data(wr_data), .rd_en(rd_en), .flash_rdata(flash_rdata),
    .rd_data(rd_data), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .rtc_irq(rtc_irq), .cart_irq_n(cart_irq_n)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [23:0] a, input logic [15:0] d);
    @(negedge clk);
    bus_addr = a; wr_data = d; wr_strobe = 1'b1;
    @(negedge clk);
    wr_strobe = 1'b0;
    #1;
  endtask

  task automatic rd(input logic [23:0] a, input logic [15:0] fl, output logic [15:0] v);
    @(negedge clk);
    bus_addr = a; flash_rdata = fl; rd_en = 1'b1;
    #1 v = rd_data;
    rd_en = 1'b0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    check("R1 pin_out", {13'b0, pin_out}, 16'h0);
    check("R1 pin_oe", {13'b0, pin_oe}, 16'h0);
    rd(24'hC8, 16'hBEEF, v);
    check("R1 write-only mode", v, 16'hBEEF);
  endtask

  task automatic t_irq;
    rtc_irq = 1'b1; #1;
    check("R8 irq high", {15'b0, cart_irq_n}, 16'h0);
    rtc_irq = 1'b0; #1;
    check("R8 irq low", {15'b0, cart_irq_n}, 16'h1);
  endtask

  task automatic t_value;
    wr(24'hC4, 16'h0005);
    check("R2 value 101", {13'b0, pin_out}, 16'h5);
    wr(24'hC4, 16'hFFFA);
    check("R2 upper ignored", {13'b0, pin_out}, 16'h2);
  endtask

  task automatic t_dir;
    wr(24'hC6, 16'h0003);
    check("R3 dir", {13'b0, pin_oe}, 16'h3);
  endtask

  task automatic t_write_only;
    logic [15:0] v;
    rd(24'hC4, 16'hA5A5, v); check("R4 value reg", v, 16'hA5A5);
    rd(24'hC6, 16'h5A5A, v); check("R4 dir reg", v, 16'h5A5A);
    rd(24'hC8, 16'h0F0F, v); check("R4 mode reg", v, 16'h0F0F);
  endtask

  task automatic t_readable;
    logic [15:0] v;
    wr(24'hC8, 16'hFFFF);
    rd(24'hC6, 16'hFFFF, v); check("R6 dir readback", v, 16'h0003);
    rd(24'hC8, 16'hFFFF, v); check("R6 mode readback", v, 16'h0001);
    pin_in = 3'b100;
    rd(24'hC4, 16'hFFFF, v); check("R5 mixed pins a", v, 16'h0006);
    pin_in = 3'b011;
    rd(24'hC4, 16'hFFFF, v); check("R5 mixed pins b", v, 16'h0002);
    wr(24'hC6, 16'h0000);
    pin_in = 3'b101;
    rd(24'hC4, 16'hFFFF, v); check("R5 all inputs", v, 16'h0005);
    rd(24'h000100, 16'h7777, v); check("R9 outside", v, 16'h7777);
  endtask

  task automatic t_decode;
    logic [15:0] v;
    wr(24'h0100C4, 16'h0007);
    check("R7 high alias write", {13'b0, pin_out}, 16'h2);
    wr(24'h0000C7, 16'h0007);
    check("R7 odd alias write", {13'b0, pin_oe}, 16'h0);
    rd(24'h0100C6, 16'h4321, v); check("R7 high alias read", v, 16'h4321);
    rd(24'h0000C5, 16'h1111, v); check("R7 odd alias read", v, 16'h1111);
    wr(24'h0000C9, 16'h0000);
    rd(24'hC8, 16'h2222, v); check("R7 mode kept", v, 16'h0001);
    wr(24'hC8, 16'h0000);
    rd(24'hC8, 16'h3333, v); check("R4 back to write-only", v, 16'h3333);
    rd(24'h000100, 16'h6666, v); check("R9 outside write-only", v, 16'h6666);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_irq();
    t_value();
    t_dir();
    t_write_only();
    t_readable();
    t_decode();
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule